// File: doc/BRIEF.md
# Local Bus Slave Ready Handshake

This block runs the slave side of accesses to the I/O register space of a 32-bit local-bus peripheral. When the address strobe is sampled low, it looks at the write/read, data/control and memory/IO qualifiers together with a chip-select decode. It claims only I/O data cycles that hit the decode. For a write it strobes the register port and pulses ready for one clock. For a read it first fetches the register word. It then pulses ready for one clock and keeps the word driven on the data bus until the master returns a ready acknowledgement on a separate input.

The controller is a five-state machine. IDLE goes to WR_ACK on a claimed write (transition ACCEPT_WR) and to RD_FETCH on a claimed read (transition ACCEPT_RD). WR_ACK always goes back to IDLE (WR_DONE). RD_FETCH always goes to RD_ACK (FETCHED). RD_ACK goes to IDLE when ready-return is sampled low at the edge that closes the ready pulse (RTN_FAST); otherwise it goes to RD_HOLD (RTN_WAIT). RD_HOLD stays put until ready-return is sampled low, then goes to IDLE (RTN_SEEN). The ready output may be wired straight back to the ready-return input: the read then closes on the edge after the pulse.

Top module: `lbus_slave_rdy`

## Requirements
- R1: A cycle is claimed only if, at a rising edge in IDLE, ads_n=0, cyc_mem=0 (I/O), cyc_data=1 (data) and cs_hit=1. Any other combination produces no ready pulse, no register strobe and no data drive.
- R2: For a claimed write (cyc_wr=1), in the cycle after the accepting edge rf_we=1, rf_wdata=data_in, rf_addr equals the latched address and rdy_n=0. The block is back in IDLE in the cycle after that.
- R3: For a claimed read (cyc_wr=0), rf_re=1 in the cycle after the accepting edge. In the next cycle rdy_n=0 and data_oe=1, and data_out holds the rf_rdata value sampled at the end of the fetch cycle.
- R4: rdy_n is low for exactly one clock per access and is never held low across two cycles.
- R5: After a read's ready pulse, data_oe stays 1 with data_out unchanged. This lasts until a rising edge at or after the end of the ready cycle samples rdyrtn_n=0. data_oe is 0 in the cycle after that edge.
- R6: A low level on rdyrtn_n before the ready pulse does not end the read early, and the pulse and data drive still occur.
- R7: rdyrtn_n has no effect on a write, which completes at the end of its ready cycle.
- R8: An address strobe sampled in any state other than IDLE (a pending read or a write ready cycle) is ignored and causes no register strobe.
- R9: With rdyrtn_n tied to rdy_n, a read drives data for the ready cycle only and returns to IDLE.
- R10: A synchronous reset (rst_n=0 at an edge) returns the block to IDLE with rdy_n=1, data_oe=0, rf_we=0 and rf_re=0, including in the middle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ads_n | input | 1 | Address strobe, active low |
| cyc_wr | input | 1 | 1 = write, 0 = read |
| cyc_data | input | 1 | 1 = data cycle, 0 = control cycle |
| cyc_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cs_hit | input | 1 | Chip-select decode hit |
| addr | input | ADDR_W | Access address |
| data_in | input | DATA_W | Write data from the bus |
| data_out | output | DATA_W | Read data toward the bus |
| data_oe | output | 1 | Output enable for data_out |
| rdy_n | output | 1 | Ready pulse, active low |
| rdyrtn_n | input | 1 | Ready return from the master, active low |
| rf_addr | output | ADDR_W | Register port address |
| rf_we | output | 1 | Register port write strobe |
| rf_re | output | 1 | Register port read strobe |
| rf_wdata | output | DATA_W | Register port write data |
| rf_rdata | input | DATA_W | Register port read data |

## Verification
The bench targets the read release timing. It returns the acknowledgement on the edge that closes the ready cycle, one edge later and several edges later. A design that sampled ready-return one edge late would keep the bus driven an extra cycle, and one that ignored it would never release. It holds ready-return low before a read starts, which catches a design that lets a stale level cut the read short before its ready pulse. It also runs with ready fed back into ready-return, which locks up a design that only looks after the pulse. Finally, it strobes during a pending read and a write ready cycle, sends unclaimed cycle types, and resets in the middle of a read: a design that decoded loosely or accepted early would corrupt a register that is read back later.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_ACK   = 3'd1,
        ST_RD_FETCH = 3'd2,
        ST_RD_ACK   = 3'd3,
        ST_RD_HOLD  = 3'd4
    } lbs_state_e;

    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_IORD = 2'd1,
        CYC_IOWR = 2'd2
    } lbs_cyc_e;

endpackage

// File: rtl/lbs_decode.sv
module lbs_decode
    import lbs_pkg::*;
(
    input  logic     ads_n,
    input  logic     cyc_wr,
    input  logic     cyc_data,
    input  logic     cyc_mem,
    input  logic     cs_hit,
    output lbs_cyc_e kind
);

    logic io_data_hit;

    // Only I/O data cycles that hit the select decode are claimed.
    assign io_data_hit = !ads_n && !cyc_mem && cyc_data && cs_hit;

    always_comb begin
        kind = CYC_NONE;
        if (io_data_hit) begin
            kind = cyc_wr ? CYC_IOWR : CYC_IORD;
        end
    end

endmodule

// File: rtl/lbs_fsm.sv
module lbs_fsm
    import lbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lbs_cyc_e kind,
    input  logic     rdyrtn_n,
    output logic     accept,
    output logic     fetch,
    output logic     wr_strobe,
    output logic     drive,
    output logic     rdy_n
);

    lbs_state_e state_q;
    lbs_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (kind == CYC_IOWR) begin
                    state_d = ST_WR_ACK;
                end else if (kind == CYC_IORD) begin
                    state_d = ST_RD_FETCH;
                end
            end
            ST_WR_ACK: begin
                state_d = ST_IDLE;
            end
            ST_RD_FETCH: begin
                state_d = ST_RD_ACK;
            end
            ST_RD_ACK: begin
                // Acknowledge sampled at the edge closing the pulse counts,
                // so ready tied to ready-return still completes.
                state_d = rdyrtn_n ? ST_RD_HOLD : ST_IDLE;
            end
            ST_RD_HOLD: begin
                if (!rdyrtn_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        accept    = 1'b0;
        fetch     = 1'b0;
        wr_strobe = 1'b0;
        drive     = 1'b0;
        rdy_n     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                accept = (kind != CYC_NONE);
            end
            ST_WR_ACK: begin
                wr_strobe = 1'b1;
                rdy_n     = 1'b0;
            end
            ST_RD_FETCH: begin
                fetch = 1'b1;
            end
            ST_RD_ACK: begin
                drive = 1'b1;
                rdy_n = 1'b0;
            end
            ST_RD_HOLD: begin
                drive = 1'b1;
            end
            default: begin
                rdy_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lbs_hold.sv
module lbs_hold #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q <= addr_in;
            end
            if (capture) begin
                rdata_q <= rdata_in;
            end
        end
    end

endmodule

// File: rtl/lbus_slave_rdy.sv
module lbus_slave_rdy
    import lbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_n,
    input  logic              cyc_wr,
    input  logic              cyc_data,
    input  logic              cyc_mem,
    input  logic              cs_hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rdy_n,
    input  logic              rdyrtn_n,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic              rf_re,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);

    lbs_cyc_e kind;
    logic     accept;
    logic     fetch;
    logic     wr_strobe;
    logic     drive;

    lbs_decode u_decode (
        .ads_n    (ads_n),
        .cyc_wr   (cyc_wr),
        .cyc_data (cyc_data),
        .cyc_mem  (cyc_mem),
        .cs_hit   (cs_hit),
        .kind     (kind)
    );

    lbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .rdyrtn_n  (rdyrtn_n),
        .accept    (accept),
        .fetch     (fetch),
        .wr_strobe (wr_strobe),
        .drive     (drive),
        .rdy_n     (rdy_n)
    );

    lbs_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .addr_in  (addr),
        .capture  (fetch),
        .rdata_in (rf_rdata),
        .addr_q   (rf_addr),
        .rdata_q  (data_out)
    );

    assign data_oe  = drive;
    assign rf_we    = wr_strobe;
    assign rf_re    = fetch;
    assign rf_wdata = data_in;

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ads_n,
    input logic              cyc_wr,
    input logic              cyc_data,
    input logic              cyc_mem,
    input logic              cs_hit,
    input logic              rdy_n,
    input logic              rdyrtn_n,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out,
    input logic              rf_we,
    input logic              rf_re
);

    p_wr_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(!ads_n && !cyc_mem && cyc_data && cs_hit && cyc_wr));

    p_rd_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |-> $past(!ads_n && !cyc_mem && cyc_data && cs_hit && !cyc_wr));

    p_we_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !rdy_n);

    p_fetch_then_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |=> (!rdy_n && data_oe));

    p_rdy_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |=> rdy_n);

    p_hold_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && rdyrtn_n) |=> (data_oe && $stable(data_out)));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && !rdyrtn_n) |=> !data_oe);

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rdy_n && !data_oe && !rf_we && !rf_re));

endmodule

bind lbus_slave_rdy lbs_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_lbus_slave_rdy.sv
`timescale 1ns/1ps
module sim_lbus_slave_rdy;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ads_n = 1'b1;
    logic          cyc_wr = 1'b0;
    logic          cyc_data = 1'b1;
    logic          cyc_mem = 1'b0;
    logic          cs_hit = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe;
    logic          rdy_n;
    logic          rdyrtn_n;
    logic          rtn_drv = 1'b1;
    logic          tie = 1'b0;
    logic [AW-1:0] rf_addr;
    logic          rf_we;
    logic          rf_re;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] rf_rdata;

    logic [DW-1:0] regs [256];
    logic [DW-1:0] shadow [256];

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R10";

    always #2 clk = ~clk;

    assign rdyrtn_n = tie ? rdy_n : rtn_drv;
    assign rf_rdata = regs[rf_addr];

    lbus_slave_rdy #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cyc_wr(cyc_wr),
        .cyc_data(cyc_data), .cyc_mem(cyc_mem), .cs_hit(cs_hit),
        .addr(addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .rdy_n(rdy_n), .rdyrtn_n(rdyrtn_n),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_re(rf_re),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    // Register file behind the port
    always @(posedge clk) begin
        if (rf_we) regs[rf_addr] <= rf_wdata;
    end

    // Snapshot of what the design sees at each rising edge
    logic          s_rst_n, s_ads_n, s_wr, s_dat, s_mem, s_cs, s_rtn;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_din;
    always @(posedge clk) begin
        s_rst_n = rst_n; s_ads_n = ads_n; s_wr = cyc_wr; s_dat = cyc_data;
        s_mem = cyc_mem; s_cs = cs_hit; s_rtn = rdyrtn_n;
        s_addr = addr; s_din = data_in;
    end

    // Behavioural reference: write-busy flag and read age
    bit            m_wr_busy = 1'b0;
    int            m_rd_age  = -1;
    logic [AW-1:0] m_addr    = '0;
    logic [DW-1:0] m_data    = '0;

    task automatic model_step();
        if (!s_rst_n) begin
            m_wr_busy = 1'b0;
            m_rd_age  = -1;
        end else if (m_wr_busy) begin
            shadow[m_addr] = s_din;
            m_wr_busy = 1'b0;
        end else if (m_rd_age == 0) begin
            m_rd_age = 1;
            m_data   = shadow[m_addr];
        end else if (m_rd_age >= 1) begin
            m_rd_age = s_rtn ? 2 : -1;
        end else if (!s_ads_n && !s_mem && s_dat && s_cs) begin
            m_addr = s_addr;
            if (s_wr) m_wr_busy = 1'b1;
            else      m_rd_age  = 0;
        end
    endtask

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) at %0t: actual %h expected %h", tag, cur_req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R4 rdy_n", {31'd0, rdy_n}, {31'd0, !(m_wr_busy || m_rd_age == 1)});
        chk("R2 rf_we", {31'd0, rf_we}, {31'd0, m_wr_busy});
        chk("R3 rf_re", {31'd0, rf_re}, {31'd0, m_rd_age == 0});
        chk("R5 data_oe", {31'd0, data_oe}, {31'd0, m_rd_age >= 1});
        if (m_rd_age >= 1) chk("R3 data_out", data_out, m_data);
        if (m_wr_busy || m_rd_age == 0) chk("R2 rf_addr", {24'd0, rf_addr}, {24'd0, m_addr});
        if (m_wr_busy) chk("R2 rf_wdata", rf_wdata, data_in);
    endtask

    task automatic tick();
        @(negedge clk);
        model_step();
        compare_all();
    endtask

    task automatic issue(bit wr, bit dat, bit mem, bit cs, logic [AW-1:0] a, logic [DW-1:0] d);
        ads_n = 1'b0; cyc_wr = wr; cyc_data = dat; cyc_mem = mem; cs_hit = cs;
        addr = a; data_in = d;
        tick();
        ads_n = 1'b1;
    endtask

    task automatic read_wait(logic [AW-1:0] a, int waits);
        issue(1'b0, 1'b1, 1'b0, 1'b1, a, '0);
        tick();
        for (int i = 0; i < waits; i++) tick();
        rtn_drv = 1'b0;
        tick();
        rtn_drv = 1'b1;
        tick();
        tick();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            regs[i] = '0;
            shadow[i] = '0;
        end
    end

    bit done = 1'b0;
    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (%s): actual hung expected done", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cur_req = "R10";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        cur_req = "R7";
        rtn_drv = 1'b1;
        issue(1'b1, 1'b1, 1'b0, 1'b1, 8'h03, 32'hA5A5_0003); tick(); tick();
        issue(1'b1, 1'b1, 1'b0, 1'b1, 8'h07, 32'h1234_5677); tick(); tick();
        rtn_drv = 1'b0;
        issue(1'b1, 1'b1, 1'b0, 1'b1, 8'h20, 32'hDEAD_BEEF); tick(); tick();
        rtn_drv = 1'b1;

        cur_req = "R1";
        issue(1'b1, 1'b1, 1'b1, 1'b1, 8'h03, 32'h0BAD_0001); tick(); tick();
        issue(1'b1, 1'b1, 1'b0, 1'b0, 8'h03, 32'h0BAD_0002); tick(); tick();
        issue(1'b1, 1'b0, 1'b0, 1'b1, 8'h03, 32'h0BAD_0003); tick(); tick();
        issue(1'b0, 1'b1, 1'b1, 1'b1, 8'h03, 32'h0); tick(); tick();

        cur_req = "R5";
        read_wait(8'h03, 0);
        read_wait(8'h07, 1);
        read_wait(8'h20, 4);

        cur_req = "R6";
        rtn_drv = 1'b0;
        issue(1'b0, 1'b1, 1'b0, 1'b1, 8'h07, '0);
        repeat (4) tick();
        rtn_drv = 1'b1;
        tick();

        cur_req = "R8";
        issue(1'b0, 1'b1, 1'b0, 1'b1, 8'h03, '0);
        tick(); tick();
        issue(1'b1, 1'b1, 1'b0, 1'b1, 8'h07, 32'hFFFF_0000);
        tick();
        rtn_drv = 1'b0; tick(); rtn_drv = 1'b1; tick();
        issue(1'b1, 1'b1, 1'b0, 1'b1, 8'h10, 32'h0000_0010);
        issue(1'b1, 1'b1, 1'b0, 1'b1, 8'h07, 32'hFFFF_1111);
        tick(); tick();
        read_wait(8'h07, 0);
        read_wait(8'h10, 0);

        cur_req = "R9";
        tie = 1'b1;
        issue(1'b0, 1'b1, 1'b0, 1'b1, 8'h20, '0);
        repeat (4) tick();
        issue(1'b0, 1'b1, 1'b0, 1'b1, 8'h03, '0);
        repeat (4) tick();
        tie = 1'b0;

        cur_req = "R10";
        issue(1'b0, 1'b1, 1'b0, 1'b1, 8'h07, '0);
        tick(); tick();
        rst_n = 1'b0; tick();
        rst_n = 1'b1; tick(); tick();
        read_wait(8'h03, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule